// File: doc/BRIEF.md
# Two-Wire Serial Word Receiver Bit Decoder

This block turns a pair of digitized comparator outputs into 32-bit data words. One input is high while the line sits at its positive "one" level. The other is high while the line sits at its negative "zero" level. When both are low the line is in its null state, which separates bits and words. A divider derives a receive tick running at ten times the bit rate. A bit is accepted only after three consecutive tick samples agree, which means the level is re-checked two ticks after it first appears. Accepted bits are shifted into a word register in arrival order. A long null period marks the boundary between words.

A configuration input selects either the line comparators or a loopback stream from the local transmitter. A build parameter sets up the second receiver of a pair, which sees the loopback stream with its polarity reversed. When the thirty-second bit lands, the block raises a one-cycle ready strobe. It presents the word as two 16-bit halves together with a parity status flag, and holds them until the next full word arrives. The speed and source settings are taken in only while the line is idle.

Top module: `a429_rx_decoder`

## Requirements
- R1: The selected pair is decoded as one = {one-input=1, zero-input=0} and zero = {0,1}. Both low, or both high, is null and never produces a bit.
- R2: A bit is accepted only when three consecutive tick samples show the same non-null level. A level that lasts two ticks or less yields no bit. A level of exactly three ticks yields one bit.
- R3: A single level pulse yields exactly one bit, however long it lasts. The next bit needs at least one null sample first.
- R4: The first accepted bit of a word is bit 1. `word1[0]` holds bit 1 and `word1[15]` holds bit 16. `word2[0]` holds bit 17 and `word2[15]` holds bit 32.
- R5: `word_rdy` is high for exactly one clock. With a tick on every clock, it is high in the fourth clock counted from the clock whose edge first samples the 32nd bit's level. `word1`, `word2` and `par_err` change only on that same edge, and they hold between strobes.
- R6: `par_err` is 0 when the presented word has an odd number of ones and 1 when it has an even number.
- R7: After 4×10 = 40 consecutive null ticks the bit count is cleared, and the receiver counts as idle. A run of 39 null ticks does not clear it. A word cut off by a clear produces no strobe and leaves the outputs unchanged.
- R8: Once 32 bits have been accepted, further bits before the next clear are ignored. The presented word stays the first 32 bits.
- R9: `loop_n`=0 selects the loopback inputs `st_one`/`st_zero`, and the line inputs are then ignored. `loop_n`=1 selects `line_one`/`line_zero`.
- R10: With `INV_LOOP`=1, the loopback pair is swapped before selection, so a loopback word arrives bitwise inverted. With `INV_LOOP`=0 it passes unchanged.
- R11: `speed_lo`=0 gives one tick every `HI_DIV` clocks. `speed_lo`=1 gives one tick every `LO_DIV` clocks, so the level and null durations scale with it.
- R12: `speed_lo` and `loop_n` are latched only while the receiver is idle. Changes made during a word take effect after the next clear.
- R13: After reset the outputs are zero, the receiver is idle, and the line inputs are selected at high speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_lo | input | 1 | 1 selects the low bit-rate tick divider |
| loop_n | input | 1 | Active low: 0 selects the loopback stream |
| line_one | input | 1 | Line comparator: positive level present |
| line_zero | input | 1 | Line comparator: negative level present |
| st_one | input | 1 | Loopback stream: one level |
| st_zero | input | 1 | Loopback stream: zero level |
| word1 | output | 16 | Bits 1 to 16 of the last complete word |
| word2 | output | 16 | Bits 17 to 32 of the last complete word |
| par_err | output | 1 | 1 when the presented word has an even number of ones |
| word_rdy | output | 1 | One-clock strobe when a complete word is presented |

## Verification
The bench runs the high-speed divider at one clock per tick, so every latency is an exact clock count. The ready strobe is due in the fourth clock after the 32nd bit's level is driven: the sample register, the confirmation register and the word register each add one clock. The bench samples on the falling edge one clock before that point, at it, and one clock after it. Word contents and parity are checked from a capture taken on the strobe, once a full null gap has passed. The gap threshold is probed at 39 and 40 null ticks. At the low speed the tick phase is not visible, so there the bench uses level durations that give either clearly fewer than three samples or clearly more.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    localparam int WORD_BITS = 32;
    localparam int HALF_BITS = WORD_BITS / 2;
    localparam int CNT_W     = $clog2(WORD_BITS + 1);

    // Decoded level of the selected comparator pair for one tick sample.
    typedef enum logic [1:0] {
        LVL_NULL = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_ZERO = 2'd2
    } lvl_t;

    // Settings that may only change between words.
    typedef struct packed {
        logic slow;
        logic loop_n;
    } rx_cfg_t;

    // Both-high is not a legal line state and is treated as null.
    function automatic lvl_t lvl_of(input logic one_in, input logic zero_in);
        lvl_t r;
        case ({one_in, zero_in})
            2'b10:   r = LVL_ONE;
            2'b01:   r = LVL_ZERO;
            default: r = LVL_NULL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/a429_rx_tick.sv
module a429_rx_tick #(
    parameter int HI_DIV = 50,
    parameter int LO_DIV = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    output logic tick
);
    localparam int MAXD = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = slow ? CW'(LO_DIV - 1) : CW'(HI_DIV - 1);
        tick = (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/a429_rx_bitdet.sv
module a429_rx_bitdet
    import a429_rx_pkg::*;
#(
    parameter int OVS      = 10,
    parameter int GAP_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  lvl_t lvl_in,
    output logic bit_vld,
    output logic bit_val,
    output logic gap_pulse,
    output logic idle
);
    localparam int GAP_TICKS = OVS * GAP_BITS;
    localparam int GW        = $clog2(GAP_TICKS + 1);

    lvl_t          h0, h1;     // previous two tick samples
    logic          armed;      // a null has been seen since the last bit
    logic [GW-1:0] null_run;

    assign idle = (null_run == GW'(GAP_TICKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            h0        <= LVL_NULL;
            h1        <= LVL_NULL;
            armed     <= 1'b1;
            bit_vld   <= 1'b0;
            bit_val   <= 1'b0;
            gap_pulse <= 1'b0;
            null_run  <= GW'(GAP_TICKS);
        end else begin
            bit_vld   <= 1'b0;
            gap_pulse <= 1'b0;
            if (tick) begin
                h0 <= lvl_in;
                h1 <= h0;
                if (lvl_in == LVL_NULL) begin
                    armed <= 1'b1;
                    if (null_run < GW'(GAP_TICKS)) begin
                        null_run <= null_run + 1'b1;
                    end
                    if (null_run == GW'(GAP_TICKS - 1)) begin
                        gap_pulse <= 1'b1;
                    end
                end else begin
                    null_run <= '0;
                    // detected two ticks ago, confirmed now
                    if (armed && lvl_in == h0 && lvl_in == h1) begin
                        bit_vld <= 1'b1;
                        bit_val <= (lvl_in == LVL_ONE);
                        armed   <= 1'b0;
                    end
                end
            end
        end
    end

    assert_bit_single_R3: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld);

    assert_bit_not_idle_R7: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> !idle);

    assert_gap_sets_idle_R7: assert property (@(posedge clk) disable iff (rst)
        gap_pulse |-> idle);

endmodule

// File: rtl/a429_rx_framer.sv
module a429_rx_framer
    import a429_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_vld,
    input  logic                 bit_val,
    input  logic                 gap_pulse,
    output logic [WORD_BITS-1:0] word_q,
    output logic                 par_q,
    output logic                 word_rdy
);
    logic [CNT_W-1:0]     count;
    logic [WORD_BITS-1:0] sh;
    logic [WORD_BITS-1:0] sh_next;

    // first received bit ends up at index 0
    assign sh_next = {bit_val, sh[WORD_BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            sh       <= '0;
            word_q   <= '0;
            par_q    <= 1'b0;
            word_rdy <= 1'b0;
        end else begin
            word_rdy <= 1'b0;
            if (gap_pulse) begin
                count <= '0;
            end else if (bit_vld && count < CNT_W'(WORD_BITS)) begin
                sh    <= sh_next;
                count <= count + 1'b1;
                if (count == CNT_W'(WORD_BITS - 1)) begin
                    word_q   <= sh_next;
                    par_q    <= ~(^sh_next);
                    word_rdy <= 1'b1;
                end
            end
        end
    end

    assert_rdy_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        word_rdy |=> !word_rdy);

    assert_rdy_follows_bit_R5: assert property (@(posedge clk) disable iff (rst)
        word_rdy |-> $past(bit_vld));

    assert_word_held_R5: assert property (@(posedge clk) disable iff (rst)
        !word_rdy |-> (word_q == $past(word_q) && par_q == $past(par_q)));

endmodule

// File: rtl/a429_rx_decoder.sv
module a429_rx_decoder
    import a429_rx_pkg::*;
#(
    parameter int OVS      = 10,
    parameter int GAP_BITS = 4,
    parameter int HI_DIV   = 50,
    parameter int LO_DIV   = 400,
    parameter bit INV_LOOP = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 speed_lo,
    input  logic                 loop_n,
    input  logic                 line_one,
    input  logic                 line_zero,
    input  logic                 st_one,
    input  logic                 st_zero,
    output logic [HALF_BITS-1:0] word1,
    output logic [HALF_BITS-1:0] word2,
    output logic                 par_err,
    output logic                 word_rdy
);
    rx_cfg_t              cfg_q;
    logic                 st_one_eff, st_zero_eff;
    logic                 sel_one, sel_zero;
    lvl_t                 lvl_in;
    logic                 tick, bit_vld, bit_val, gap_pulse, idle;
    logic [WORD_BITS-1:0] word_q;

    generate
        if (INV_LOOP) begin : g_loop_inv
            assign st_one_eff  = st_zero;
            assign st_zero_eff = st_one;
        end else begin : g_loop_dir
            assign st_one_eff  = st_one;
            assign st_zero_eff = st_zero;
        end
    endgenerate

    always_comb begin
        sel_one  = cfg_q.loop_n ? line_one  : st_one_eff;
        sel_zero = cfg_q.loop_n ? line_zero : st_zero_eff;
        lvl_in   = lvl_of(sel_one, sel_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.slow   <= 1'b0;
            cfg_q.loop_n <= 1'b1;
        end else if (idle) begin
            cfg_q.slow   <= speed_lo;
            cfg_q.loop_n <= loop_n;
        end
    end

    a429_rx_tick #(
        .HI_DIV (HI_DIV),
        .LO_DIV (LO_DIV)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .slow (cfg_q.slow),
        .tick (tick)
    );

    a429_rx_bitdet #(
        .OVS      (OVS),
        .GAP_BITS (GAP_BITS)
    ) u_bitdet (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .lvl_in    (lvl_in),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .gap_pulse (gap_pulse),
        .idle      (idle)
    );

    a429_rx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .gap_pulse (gap_pulse),
        .word_q    (word_q),
        .par_q     (par_err),
        .word_rdy  (word_rdy)
    );

    assign word1 = word_q[HALF_BITS-1:0];
    assign word2 = word_q[WORD_BITS-1:HALF_BITS];

    assert_cfg_held_busy_R12: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(cfg_q));

    assert_rdy_not_idle_R7: assert property (@(posedge clk) disable iff (rst)
        word_rdy |-> !idle);

endmodule

// File: tb/a429_rx_decoder_bench.sv
`timescale 1ns/1ps
module a429_rx_decoder_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        speed_lo = 1'b0, loop_n = 1'b1;
    logic        line_one = 1'b0, line_zero = 1'b0;
    logic        st_one = 1'b0, st_zero = 1'b0;
    logic [15:0] w1_a, w2_a, w1_b, w2_b;
    logic        par_a, par_b, rdy_a, rdy_b;

    a429_rx_decoder #(.HI_DIV(1), .LO_DIV(3), .INV_LOOP(1'b0)) u_a429_rx_decoder (
        .clk(clk), .rst(rst), .speed_lo(speed_lo), .loop_n(loop_n),
        .line_one(line_one), .line_zero(line_zero), .st_one(st_one), .st_zero(st_zero),
        .word1(w1_a), .word2(w2_a), .par_err(par_a), .word_rdy(rdy_a));

    a429_rx_decoder #(.HI_DIV(1), .LO_DIV(3), .INV_LOOP(1'b1)) u_a429_rx_decoder_inv (
        .clk(clk), .rst(rst), .speed_lo(speed_lo), .loop_n(loop_n),
        .line_one(line_one), .line_zero(line_zero), .st_one(st_one), .st_zero(st_zero),
        .word1(w1_b), .word2(w2_b), .par_err(par_b), .word_rdy(rdy_b));

    int total = 0, bad = 0;
    int cur_div = 1;
    int nstb_a = 0, nstb_b = 0;
    logic [31:0] cap_a = '0, cap_b = '0;
    logic        capp_a = 1'b0, capp_b = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rdy_a) begin nstb_a++; cap_a = {w2_a, w1_a}; capp_a = par_a; end
            if (rdy_b) begin nstb_b++; cap_b = {w2_b, w1_b}; capp_b = par_b; end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n * cur_div) @(negedge clk);
    endtask

    task automatic set_lvl(input bit st, input bit h, input bit l);
        if (st) begin st_one = h; st_zero = l; end
        else begin line_one = h; line_zero = l; end
    endtask

    task automatic send_bit(input bit st, input bit b, input int lt, input int nt);
        set_lvl(st, b, !b);
        tk(lt);
        set_lvl(st, 1'b0, 1'b0);
        tk(nt);
    endtask

    task automatic send_range(input bit st, input logic [31:0] w, input int s, input int e, input int lt);
        for (int i = s; i < e; i++) send_bit(st, w[i % 32], lt, 5);
    endtask

    task automatic idle_gap();
        set_lvl(1'b0, 1'b0, 1'b0);
        set_lvl(1'b1, 1'b0, 1'b0);
        tk(45);
    endtask

    function automatic bit exp_par(input logic [31:0] w);
        int c = 0;
        for (int i = 0; i < 32; i++) c += int'(w[i]);
        return (c % 2) == 0;
    endfunction

    task automatic chk_word(input string tag, input int n0, input logic [31:0] w);
        chk(nstb_a == n0 + 1, {tag, " strobe count"}, 32'(nstb_a - n0), 32'd1);
        chk(cap_a == w, {tag, " word"}, cap_a, w);
        chk(capp_a == exp_par(w), {"R6 ", tag, " parity"}, {31'd0, capp_a}, {31'd0, exp_par(w)});
    endtask

    task automatic full_word(input string tag, input logic [31:0] w);
        int n0;
        n0 = nstb_a;
        send_range(1'b0, w, 0, 32, 5);
        idle_gap();
        chk_word(tag, n0, w);
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL R5 watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w, prev;
        int n0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk({w2_a, w1_a} == 32'd0, "R13 word after reset", {w2_a, w1_a}, 32'd0);
        chk({par_a, rdy_a} == 2'b00, "R13 flags after reset", {30'd0, par_a, rdy_a}, 32'd0);
        tk(5);

        // R5 exact strobe timing, R4 halves
        w = 32'hC35A_0F81;
        send_range(1'b0, w, 0, 31, 5);
        set_lvl(1'b0, w[31], !w[31]);
        repeat (3) @(negedge clk);
        chk(rdy_a == 1'b0, "R5 strobe early", {31'd0, rdy_a}, 32'd0);
        @(negedge clk);
        chk(rdy_a == 1'b1, "R5 strobe at 4th clock", {31'd0, rdy_a}, 32'd1);
        chk(w1_a == w[15:0], "R4 word1 bits 1-16", {16'd0, w1_a}, {16'd0, w[15:0]});
        chk(w2_a == w[31:16], "R4 word2 bits 17-32", {16'd0, w2_a}, {16'd0, w[31:16]});
        @(negedge clk);
        chk(rdy_a == 1'b0, "R5 strobe one clock", {31'd0, rdy_a}, 32'd0);
        set_lvl(1'b0, 1'b0, 1'b0);
        tk(5);
        idle_gap();

        // R1 R4 R6 sweep: walking one, walking zero, mixed patterns
        for (int i = 0; i < 32; i++) full_word("R1 R4 walk1", 32'd1 << i);
        for (int i = 0; i < 32; i++) full_word("R1 R4 walk0", ~(32'd1 << i));
        for (int i = 0; i < 6; i++) full_word("R6 mix", 32'(i + 1) * 32'h9E37_79B1);
        full_word("R6 zeros", 32'h0000_0000);
        full_word("R6 ones", 32'hFFFF_FFFF);

        // R2 short glitch and R1 both-high inserted mid-word
        w = 32'h1234_ABCD; n0 = nstb_a;
        send_range(1'b0, w, 0, 16, 5);
        set_lvl(1'b0, 1'b1, 1'b0); tk(2); set_lvl(1'b0, 1'b0, 1'b0); tk(5);
        set_lvl(1'b0, 1'b0, 1'b1); tk(2); set_lvl(1'b0, 1'b0, 1'b0); tk(5);
        set_lvl(1'b0, 1'b1, 1'b1); tk(6); set_lvl(1'b0, 1'b0, 1'b0); tk(5);
        send_range(1'b0, w, 16, 32, 5);
        idle_gap();
        chk_word("R2 R1 glitch and both-high ignored", n0, w);

        // R2 boundary: three-tick levels accepted
        w = 32'h5A5A_3C3C; n0 = nstb_a;
        send_range(1'b0, w, 0, 32, 3);
        idle_gap();
        chk_word("R2 three-tick levels", n0, w);

        // R3 long level gives one bit
        w = 32'h0F0F_00FF; n0 = nstb_a;
        send_range(1'b0, w, 0, 5, 5);
        send_bit(1'b0, w[5], 12, 5);
        send_range(1'b0, w, 6, 32, 5);
        idle_gap();
        chk_word("R3 long level one bit", n0, w);

        // R7 short word discarded, outputs held
        prev = w; n0 = nstb_a;
        send_range(1'b0, 32'hFFFF_0000, 0, 31, 5);
        idle_gap();
        chk(nstb_a == n0, "R7 short word no strobe", 32'(nstb_a - n0), 32'd0);
        chk({w2_a, w1_a} == prev, "R7 outputs held", {w2_a, w1_a}, prev);
        full_word("R7 word after short", 32'h8000_0001);

        // R7 gap boundary: 39 null ticks keep the word, 40 clear it
        w = 32'h6B2D_91E4; n0 = nstb_a;
        send_range(1'b0, w, 0, 16, 5);
        tk(34);
        send_range(1'b0, w, 16, 32, 5);
        idle_gap();
        chk_word("R7 39 null ticks", n0, w);
        prev = w; n0 = nstb_a;
        send_range(1'b0, 32'h7777_1111, 0, 16, 5);
        tk(35);
        send_range(1'b0, 32'h7777_1111, 16, 32, 5);
        idle_gap();
        chk(nstb_a == n0, "R7 40 null ticks clear", 32'(nstb_a - n0), 32'd0);
        chk({w2_a, w1_a} == prev, "R7 held after clear", {w2_a, w1_a}, prev);

        // R8 extra bits ignored
        w = 32'hDEAD_BEEF; n0 = nstb_a;
        send_range(1'b0, w, 0, 35, 5);
        idle_gap();
        chk_word("R8 extra bits", n0, w);
        chk({w2_a, w1_a} == w, "R8 outputs after extra bits", {w2_a, w1_a}, w);

        // R9 R10 loopback, line held at a level
        loop_n = 1'b0; tk(2);
        line_one = 1'b1;
        w = 32'h0123_4567; n0 = nstb_a;
        begin
            int nb;
            nb = nstb_b;
            send_range(1'b1, w, 0, 32, 5);
            idle_gap();
            line_one = 1'b1;
            chk_word("R9 loopback selected", n0, w);
            chk(nstb_b == nb + 1, "R10 inverted instance strobe", 32'(nstb_b - nb), 32'd1);
            chk(cap_b == ~w, "R10 inverted instance word", cap_b, ~w);
            chk(capp_b == exp_par(~w), "R10 inverted instance parity", {31'd0, capp_b}, {31'd0, exp_par(~w)});
        end
        line_one = 1'b0;
        tk(2);

        // R12 source change mid-word deferred
        w = 32'hA0B1_C2D3; n0 = nstb_a;
        send_range(1'b1, w, 0, 16, 5);
        loop_n = 1'b1;
        send_range(1'b1, w, 16, 32, 5);
        idle_gap();
        chk_word("R12 source change deferred", n0, w);
        full_word("R9 line selected again", 32'h3141_5926);

        // R11 low speed
        speed_lo = 1'b1; tk(2);
        n0 = nstb_a;
        send_range(1'b0, 32'hFACE_B00C, 0, 32, 5);
        cur_div = 3;
        idle_gap();
        chk(nstb_a == n0, "R11 fast timing rejected at low speed", 32'(nstb_a - n0), 32'd0);
        full_word("R11 low-speed word", 32'hFACE_B00C);
        speed_lo = 1'b0; tk(2);
        cur_div = 1;
        tk(2);
        full_word("R11 back to high speed", 32'h2718_2818);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule